// File: doc/BRIEF.md
# Ray Issue Scheduler with Miss Replay

This block decides, every cycle, which ray record enters a single pipeline that handles both traversal and intersection. It has three sources. A replay slot holds a ray that came back from the end of the pipeline flagged as a cache miss; that ray travelled the rest of the loop inactive and is re-entered at the head of the next loop with its id and depth unchanged. An on-chip LIFO holds secondary rays handed over by the shading stage. A primary-generator port supplies new rays with depth zero.

Priority is fixed: replay, then the LIFO, then primary generation. A non-empty LIFO always blocks primary rays, which keeps the path count bounded and avoids deadlock between shading and generation. The pipeline itself never stalls: a miss costs the missing ray one more loop, while all other rays keep moving. Shading is back-pressured when the LIFO is full, and a secondary ray whose parent has already reached the bounce limit (15 by default) is accepted and dropped, ending that path.

Top module: `ray_issue_sched`

## Requirements
- R1: After reset the LIFO is empty and no replay is pending: iss_valid_o is 0 while prim_valid_i is 0, and prim_ready_o and sec_ready_o are both 1.
- R2: A return with ret_valid_i=1 and ret_miss_i=1 is issued in the following cycle with the same id and depth, ahead of any LIFO entry or primary ray.
- R3: A return with ret_miss_i=0 is never issued again by the block.
- R4: While the LIFO holds any entry, prim_ready_o is 0; when no replay is pending, the top entry is issued and removed that cycle.
- R5: LIFO entries are issued last-in first-out.
- R6: With no replay pending and the LIFO empty, prim_ready_o is 1 and a valid primary ray is issued in the same cycle with depth 0 and its own id.
- R7: A secondary ray carries its parent depth on sec_pdepth_i; it is stored with depth parent+1 when the parent depth is below MAX_DEPTH (15), and accepted but discarded when the parent depth equals MAX_DEPTH.
- R8: When the LIFO holds STACK_DEPTH entries, sec_ready_o is 0 and an offered secondary ray is held off, not dropped; sec_ready_o returns one cycle after an entry leaves.
- R9: A secondary push and a LIFO issue in the same cycle issue the old top and keep the new ray as the next top.
- R10: At most one ray is issued per cycle, and every accepted primary, stored secondary and missed return is issued exactly once per acceptance.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prim_valid_i | input | 1 | Primary ray offered |
| prim_id_i | input | 8 | Primary ray id |
| prim_ready_o | output | 1 | Primary ray taken this cycle if valid |
| sec_valid_i | input | 1 | Secondary ray offered by shading |
| sec_id_i | input | 8 | Secondary ray id |
| sec_pdepth_i | input | 4 | Depth of the parent ray |
| sec_ready_o | output | 1 | LIFO has room |
| ret_valid_i | input | 1 | Ray leaving the pipeline end |
| ret_miss_i | input | 1 | Returning ray missed in cache |
| ret_id_i | input | 8 | Returning ray id |
| ret_depth_i | input | 4 | Returning ray depth |
| iss_valid_o | output | 1 | Ray issued into the pipeline |
| iss_id_o | output | 8 | Issued ray id |
| iss_depth_o | output | 4 | Issued ray depth |

## Verification
The case of interest is a missed-ray replay landing in the same cycle as a secondary push while the LIFO is busy, and separately a push meeting a LIFO issue. The bench provokes both from a vector table by presenting a missed return together with a secondary ray and with pending LIFO entries, then checks in the next cycles that the replay wins the slot, that the stored rays come out afterwards in reverse order, and that a ray pushed during an issue becomes the new top. A randomized run with random miss flags, a four-stage pipeline model and parent depths biased toward the limit compares every cycle against a reference model of the priority and LIFO rules.

// File: rtl/ris_pkg.sv
package ris_pkg;
  localparam int unsigned RAY_ID_W    = 8;
  localparam int unsigned RAY_DEPTH_W = 4;

  typedef struct packed {
    logic [RAY_ID_W-1:0]    id;
    logic [RAY_DEPTH_W-1:0] depth;
  } ray_t;

  // request index = priority, 0 highest
  localparam int unsigned SRC_REPLAY = 0;
  localparam int unsigned SRC_STACK  = 1;
  localparam int unsigned SRC_PRIM   = 2;
  localparam int unsigned N_SRC      = 3;
endpackage

// File: rtl/ris_lifo.sv
module ris_lifo
  import ris_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  ray_t push_data_i,
  input  logic pop_i,
  output ray_t top_o,
  output logic empty_o,
  output logic full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ray_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  // on a simultaneous pop the new entry overwrites the leaving top
  assign wr_idx  = pop_i ? top_idx : IDX_W'(cnt_q);
  assign top_o   = mem_q[top_idx];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_idx] <= push_data_i;
  end
endmodule

// File: rtl/ris_depth_gate.sv
module ris_depth_gate
  import ris_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 15
) (
  input  logic [RAY_DEPTH_W-1:0] parent_depth_i,
  output logic                   keep_o,
  output logic [RAY_DEPTH_W-1:0] child_depth_o
);
  assign keep_o        = (parent_depth_i < RAY_DEPTH_W'(MAX_DEPTH));
  assign child_depth_o = parent_depth_i + RAY_DEPTH_W'(1);
endmodule

// File: rtl/ris_replay.sv
module ris_replay
  import ris_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ret_valid_i,
  input  logic ret_miss_i,
  input  ray_t ret_ray_i,
  output logic rep_valid_o,
  output ray_t rep_ray_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_valid_o <= 1'b0;
      rep_ray_o   <= '0;
    end else begin
      rep_valid_o <= ret_valid_i & ret_miss_i;
      if (ret_valid_i & ret_miss_i) rep_ray_o <= ret_ray_i;
    end
  end
endmodule

// File: rtl/ris_arbiter.sv
module ris_arbiter #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_prio
    if (g == 0) begin : g_top
      assign gnt_o[g] = req_i[g];
    end else begin : g_low
      assign gnt_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end
endmodule

// File: rtl/ray_issue_sched.sv
module ray_issue_sched
  import ris_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8,
  parameter int unsigned MAX_DEPTH   = 15
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prim_valid_i,
  input  logic [RAY_ID_W-1:0]    prim_id_i,
  output logic                   prim_ready_o,
  input  logic                   sec_valid_i,
  input  logic [RAY_ID_W-1:0]    sec_id_i,
  input  logic [RAY_DEPTH_W-1:0] sec_pdepth_i,
  output logic                   sec_ready_o,
  input  logic                   ret_valid_i,
  input  logic                   ret_miss_i,
  input  logic [RAY_ID_W-1:0]    ret_id_i,
  input  logic [RAY_DEPTH_W-1:0] ret_depth_i,
  output logic                   iss_valid_o,
  output logic [RAY_ID_W-1:0]    iss_id_o,
  output logic [RAY_DEPTH_W-1:0] iss_depth_o
);
  logic                   rep_valid;
  ray_t                   rep_ray, stk_top, iss_ray;
  logic                   stk_push, stk_pop, stk_full, stk_empty;
  logic                   sec_keep;
  logic [RAY_DEPTH_W-1:0] sec_child_depth;
  logic [N_SRC-1:0]       req, gnt;

  ris_replay u_replay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ret_valid_i (ret_valid_i),
    .ret_miss_i  (ret_miss_i),
    .ret_ray_i   ('{id: ret_id_i, depth: ret_depth_i}),
    .rep_valid_o (rep_valid),
    .rep_ray_o   (rep_ray)
  );

  ris_depth_gate #(.MAX_DEPTH(MAX_DEPTH)) u_gate (
    .parent_depth_i (sec_pdepth_i),
    .keep_o         (sec_keep),
    .child_depth_o  (sec_child_depth)
  );

  assign sec_ready_o = ~stk_full;
  assign stk_push    = sec_valid_i & sec_ready_o & sec_keep;

  ris_lifo #(.DEPTH(STACK_DEPTH)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (stk_push),
    .push_data_i ('{id: sec_id_i, depth: sec_child_depth}),
    .pop_i       (stk_pop),
    .top_o       (stk_top),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  assign req[SRC_REPLAY] = rep_valid;
  assign req[SRC_STACK]  = ~stk_empty;
  assign req[SRC_PRIM]   = prim_valid_i;

  ris_arbiter #(.N(N_SRC)) u_arb (
    .req_i (req),
    .gnt_o (gnt)
  );

  assign stk_pop      = gnt[SRC_STACK];
  assign prim_ready_o = ~rep_valid & stk_empty;

  always_comb begin
    iss_ray = '0;
    unique case (1'b1)
      gnt[SRC_REPLAY]: iss_ray = rep_ray;
      gnt[SRC_STACK]:  iss_ray = stk_top;
      gnt[SRC_PRIM]:   iss_ray = '{id: prim_id_i, depth: '0};
      default:         iss_ray = '0;
    endcase
  end

  assign iss_valid_o = |gnt;
  assign iss_id_o    = iss_ray.id;
  assign iss_depth_o = iss_ray.depth;
endmodule

// File: rtl/ris_sched_chk.sv
module ris_sched_chk
  import ris_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 15
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   prim_valid_i,
  input logic                   prim_ready_o,
  input logic                   sec_valid_i,
  input logic                   sec_ready_o,
  input logic [RAY_DEPTH_W-1:0] sec_pdepth_i,
  input logic                   ret_valid_i,
  input logic                   ret_miss_i,
  input logic [RAY_ID_W-1:0]    ret_id_i,
  input logic [RAY_DEPTH_W-1:0] ret_depth_i,
  input logic                   iss_valid_o,
  input logic [RAY_ID_W-1:0]    iss_id_o,
  input logic [RAY_DEPTH_W-1:0] iss_depth_o,
  input logic                   stk_push,
  input logic                   stk_pop,
  input logic                   stk_full,
  input logic                   stk_empty
);
  AST_REPLAY_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_miss_i |=> iss_valid_o && iss_id_o == $past(ret_id_i)
                                  && iss_depth_o == $past(ret_depth_i)); // R2
  AST_STACK_BLOCKS_PRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stk_empty |-> !prim_ready_o); // R4
  AST_PRIM_DEPTH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_valid_i && prim_ready_o |-> iss_valid_o && iss_depth_o == '0); // R6
  AST_DEPTH_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_valid_i && sec_ready_o && sec_pdepth_i == RAY_DEPTH_W'(MAX_DEPTH) |-> !stk_push); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_full && !stk_pop |-> !stk_push); // R8
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_full && !stk_pop |=> stk_full && !sec_ready_o); // R8
  AST_POP_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_pop |-> iss_valid_o && !prim_ready_o); // R4
  AST_SEC_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_push |-> sec_valid_i); // R7
endmodule

bind ray_issue_sched ris_sched_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (.*);

// File: tb/ray_issue_sched_tb_top.sv
module ray_issue_sched_tb_top;
  localparam int unsigned SD   = 8;
  localparam int unsigned MAXD = 15;
  localparam int unsigned T    = 20;

  typedef struct packed {
    logic pv; logic [7:0] pid;
    logic sv; logic [7:0] sid; logic [3:0] spd;
    logic rv; logic rm; logic [7:0] rid; logic [3:0] rdp;
    logic e_iv; logic [7:0] e_id; logic [3:0] e_dp; logic e_pr; logic e_sr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0,8'h00,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b0,8'h00,4'd0,1'b1,1'b1}, // R1
    '{1'b1,8'h10,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h10,4'd0,1'b1,1'b1}, // R6
    '{1'b1,8'h11,1'b1,8'h20,4'd2, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h11,4'd0,1'b1,1'b1}, // R6
    '{1'b1,8'h12,1'b1,8'h21,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h20,4'd3,1'b0,1'b1}, // R9
    '{1'b1,8'h12,1'b0,8'h00,4'd0, 1'b1,1'b1,8'h30,4'd5,  1'b1,8'h21,4'd1,1'b0,1'b1}, // R4
    '{1'b1,8'h12,1'b1,8'h22,4'd15,1'b1,1'b0,8'h31,4'd0,  1'b1,8'h30,4'd5,1'b0,1'b1}, // R2
    '{1'b1,8'h12,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h12,4'd0,1'b1,1'b1}, // R3 R7
    '{1'b0,8'h00,1'b1,8'h23,4'd4, 1'b0,1'b0,8'h00,4'd0,  1'b0,8'h00,4'd0,1'b1,1'b1}, // R1
    '{1'b0,8'h00,1'b1,8'h24,4'd6, 1'b1,1'b1,8'h32,4'd7,  1'b1,8'h23,4'd5,1'b0,1'b1}, // R9
    '{1'b1,8'h13,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h32,4'd7,1'b0,1'b1}, // R2
    '{1'b1,8'h13,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h24,4'd7,1'b0,1'b1}, // R4
    '{1'b1,8'h13,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h13,4'd0,1'b1,1'b1}, // R6
    '{1'b0,8'h00,1'b1,8'h40,4'd0, 1'b1,1'b1,8'h50,4'd0,  1'b0,8'h00,4'd0,1'b1,1'b1}, // R2
    '{1'b0,8'h00,1'b1,8'h41,4'd1, 1'b1,1'b1,8'h51,4'd0,  1'b1,8'h50,4'd0,1'b0,1'b1}, // R2
    '{1'b0,8'h00,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h51,4'd0,1'b0,1'b1}, // R2
    '{1'b0,8'h00,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h41,4'd2,1'b0,1'b1}, // R5
    '{1'b0,8'h00,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b1,8'h40,4'd1,1'b0,1'b1}, // R5
    '{1'b0,8'h00,1'b0,8'h00,4'd0, 1'b0,1'b0,8'h00,4'd0,  1'b0,8'h00,4'd0,1'b1,1'b1}  // R5
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       prim_valid_i = 0, sec_valid_i = 0, ret_valid_i = 0, ret_miss_i = 0;
  logic [7:0] prim_id_i = 0, sec_id_i = 0, ret_id_i = 0;
  logic [3:0] sec_pdepth_i = 0, ret_depth_i = 0;
  logic       prim_ready_o, sec_ready_o, iss_valid_o;
  logic [7:0] iss_id_o;
  logic [3:0] iss_depth_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(T/2) clk_i = ~clk_i;

  ray_issue_sched #(.STACK_DEPTH(SD), .MAX_DEPTH(MAXD)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic pv, input logic [7:0] pid, input logic sv, input logic [7:0] sid,
                       input logic [3:0] spd, input logic rv, input logic rm,
                       input logic [7:0] rid, input logic [3:0] rdp);
    @(negedge clk_i);
    prim_valid_i = pv; prim_id_i = pid; sec_valid_i = sv; sec_id_i = sid; sec_pdepth_i = spd;
    ret_valid_i = rv; ret_miss_i = rm; ret_id_i = rid; ret_depth_i = rdp;
    #(T/2 - 2);
  endtask

  task automatic chk_out(input string tag, input logic e_iv, input logic [7:0] e_id,
                         input logic [3:0] e_dp, input logic e_pr, input logic e_sr);
    logic [14:0] act, exp;
    act = {iss_valid_o, iss_valid_o ? iss_id_o : 8'h0, iss_valid_o ? iss_depth_o : 4'h0,
           prim_ready_o, sec_ready_o};
    exp = {e_iv, e_iv ? e_id : 8'h0, e_iv ? e_dp : 4'h0, e_pr, e_sr};
    chk(act === exp, tag, 32'(act), 32'(exp));
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 7:            return "R1 table";
      1, 2, 11:        return "R6 table";
      3, 8:            return "R9 table";
      4, 10:           return "R4 table";
      5, 9, 12, 13, 14: return "R2 table";
      6:               return "R7 R3 table";
      default:         return "R5 table";
    endcase
  endfunction

  // reference model state for the random run
  logic [11:0] m_stk [SD];
  int          m_cnt;
  logic        m_rep;
  logic [11:0] m_rep_ray;
  logic [12:0] pipe [4];

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    chk(iss_valid_o === 1'b0 && prim_ready_o === 1'b1 && sec_ready_o === 1'b1, "R1 in reset",
        {iss_valid_o, prim_ready_o, sec_ready_o}, 3'b011);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pv, TBL[i].pid, TBL[i].sv, TBL[i].sid, TBL[i].spd,
            TBL[i].rv, TBL[i].rm, TBL[i].rid, TBL[i].rdp);
      chk_out($sformatf("%s vec %0d", vtag(i), i), TBL[i].e_iv, TBL[i].e_id, TBL[i].e_dp,
              TBL[i].e_pr, TBL[i].e_sr);
    end

    // R8: fill while replays hold the slot, then offer one more
    for (int k = 0; k < 8; k++) begin
      drive(0, 0, 1, 8'(60 + k), 0, 1, 1, 8'(70 + k), 2);
      chk_out("R8 fill", k > 0, 8'(70 + k - 1), 2, 0 ^ (k == 0), 1);
    end
    drive(0, 0, 1, 8'd99, 0, 1, 1, 8'd78, 2);
    chk_out("R8 full", 1, 8'd77, 2, 0, 0);
    drive(0, 0, 1, 8'd99, 0, 0, 0, 0, 0);
    chk_out("R8 full hold", 1, 8'd78, 2, 0, 0);
    drive(0, 0, 1, 8'd99, 0, 0, 0, 0, 0);
    chk_out("R8 pop while full", 1, 8'd67, 1, 0, 0);
    drive(0, 0, 1, 8'd99, 0, 0, 0, 0, 0);
    chk_out("R8 R9 push on pop", 1, 8'd66, 1, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_out("R8 held ray kept", 1, 8'd99, 1, 0, 1);
    for (int k = 5; k >= 0; k--) begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk_out("R5 drain", 1, 8'(60 + k), 1, 0, 1);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_out("R1 idle after drain", 0, 0, 0, 1, 1);

    // R10: random run against a reference model, four-stage pipeline, random misses
    m_cnt = 0; m_rep = 0; m_rep_ray = '0;
    for (int s = 0; s < 4; s++) pipe[s] = '0;
    for (int c = 0, pid = 0; c < 3000; c++) begin
      logic        pv, sv, rm, e_iv, e_pr, e_sr, e_pop;
      logic [3:0]  spd;
      logic [11:0] e_ray;
      pv  = ($urandom % 3) != 0;
      sv  = ($urandom % 2) != 0;
      spd = (($urandom % 4) == 0) ? 4'd15 : 4'($urandom % 15);
      rm  = ($urandom % 10) < 3;
      drive(pv, 8'(pid), sv, 8'($urandom), spd, pipe[3][12], pipe[3][12] & rm,
            pipe[3][11:4], pipe[3][3:0]);
      e_pr = !m_rep && m_cnt == 0;
      e_sr = m_cnt < SD;
      e_pop = 0;
      if (m_rep) begin e_iv = 1; e_ray = m_rep_ray; end
      else if (m_cnt > 0) begin e_iv = 1; e_ray = m_stk[m_cnt-1]; e_pop = 1; end
      else if (pv) begin e_iv = 1; e_ray = {8'(pid), 4'd0}; end
      else begin e_iv = 0; e_ray = '0; end
      chk_out("R10 R7 random", e_iv, e_ray[11:4], e_ray[3:0], e_pr, e_sr);
      if (pv && e_pr) pid++;
      if (e_pop) m_cnt--;
      if (sv && e_sr && spd < MAXD) begin
        m_stk[m_cnt] = {sec_id_i, spd + 4'd1};
        m_cnt++;
      end
      m_rep = ret_valid_i && ret_miss_i;
      m_rep_ray = {ret_id_i, ret_depth_i};
      for (int s = 3; s > 0; s--) pipe[s] = pipe[s-1];
      pipe[0] = {iss_valid_o, iss_id_o, iss_depth_o};
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule